// File: doc/BRIEF.md
# 5/3 Lifting Synthesis Engine

This block rebuilds a one-dimensional integer signal from its reversible 5/3 wavelet coefficients, working in place inside a small register file that it owns. A run covers the words at `first`, `first+stride`, ..., `last`. The engine reads them as an interleaved sequence: position k of the run holds a low-pass coefficient when k is even and a high-pass coefficient when k is odd. It first undoes the update step over all even positions. It then undoes the predict step over all odd positions, using the even samples it has just restored. Each result overwrites its own word. Neighbours that fall outside the run are taken from the mirror image about the run's end. This is the same symmetric extension a forward 5/3 pass uses, so the round trip is exact for runs of either parity.

A host loads coefficients and reads back samples through a plain word port. A run is launched with a one-cycle `start_i` together with its bounds. `busy_o` covers the run. `ready_o` pulses for one cycle once the last word has been written back. The block has no streaming interface, so nothing at its edge is subject to back-pressure. The host simply waits for `ready_o` before it reads the results.

Top module: `lift53_synth`

## Requirements
- R1: After reset `busy_o` and `ready_o` are 0 and every register-file word reads back as 0.
- R2: For each even run position k, the new word is s[k] - floor((d[k-1] + d[k+1] + 2) / 4). A missing left neighbour uses d[1]. A missing right neighbour uses d[k-1], which happens when the run length L is odd. Arithmetic is two's complement, signed, DATA_W bits.
- R3: After all even positions are done, each odd position k is rewritten as d[k] + floor((x[k-1] + x[k+1]) / 2) from the restored even samples. A missing right neighbour, which happens when L is even, uses x[k-1].
- R4: A run applied to the output of a forward 5/3 lifting pass with the same mirror extension restores the original integers exactly, for both even and odd L.
- R5: Only words at first + k*stride (0 <= k < L) are written; every other word keeps its value. A run requires last - first to be a multiple of the stride.
- R6: A run with first equal to last (L = 1) leaves the single word unchanged.
- R7: `ready_o` is high for exactly one cycle and only after the final write-back. `busy_o` is high from the cycle after the start is accepted through the `ready_o` cycle.
- R8: While `busy_o` is high, `start_i` and host writes are ignored. A start with stride 0 or with last below first is rejected: no busy, no ready, no writes.
- R9: `ready_o` rises exactly 3*L clock cycles after the clock edge that accepts `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a run when idle |
| first_i | input | ADDR_W | Address of run position 0 |
| last_i | input | ADDR_W | Address of the final run position |
| stride_i | input | ADDR_W | Address distance between run positions |
| busy_o | output | 1 | Run in progress |
| ready_o | output | 1 | One-cycle pulse after the last write-back |
| host_we_i | input | 1 | Host word write enable (ignored while busy) |
| host_addr_i | input | ADDR_W | Host word address for write and read |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Word at host_addr_i, combinational |

## Verification
A corrupted pointer or phase bit shows in the run's duration, because `ready_o` arrives early or late against 3*L cycles as soon as that run ends. It also shows as wrong words, or as damage outside the stride, in the readback that follows. A wrong latched neighbour or a bad mirror decision changes only the word being written, and only at a run edge, so a full readback after each run exposes it. Round trips on odd and even lengths catch rounding or ordering faults that a single hand-computed vector could mask, since any error in an even sample spreads into both odd neighbours.

// File: rtl/lift53_pkg.sv
package lift53_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_L,
    ST_RD_R,
    ST_WR,
    ST_DONE
  } lift_st_e;

  typedef enum logic {
    PH_EVEN,
    PH_ODD
  } lift_ph_e;
endpackage

// File: rtl/lift53_regfile.sv
module lift53_regfile #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH),
  parameter int PW     = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eng_we,
  input  logic [PW-1:0]     eng_waddr,
  input  logic [DATA_W-1:0] eng_wdata,
  input  logic [PW-1:0]     eng_raddr,
  output logic [DATA_W-1:0] eng_rdata,
  input  logic              host_ok,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (eng_we && eng_waddr == PW'(i)) begin
        mem[i] <= eng_wdata;
      end else if (host_ok && host_we && host_addr == ADDR_W'(i)) begin
        mem[i] <= host_wdata;
      end
    end
  end

  assign eng_rdata  = (eng_raddr < PW'(DEPTH)) ? mem[eng_raddr[ADDR_W-1:0]] : '0;
  assign host_rdata = mem[host_addr];
endmodule

// File: rtl/lift53_ctrl.sv
module lift53_ctrl
  import lift53_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int PW     = ADDR_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic [PW-1:0]     rd_addr,
  output logic              cap_l,
  output logic              cap_r,
  output logic              solo,
  output logic              odd_phase,
  output logic              we,
  output logic [PW-1:0]     wr_addr
);
  lift_st_e      st;
  lift_ph_e      ph;
  logic [PW-1:0] ptr, first_q, last_q, stride_q;
  logic [PW-1:0] left_a, right_a, nxt_ptr, odd_ptr;
  logic          go;

  assign go = start_i && (stride_i != '0) && (last_i >= first_i);

  assign left_a  = (ph == PH_EVEN && ptr == first_q) ? ptr + stride_q : ptr - stride_q;
  assign right_a = (ptr == last_q) ? ptr - stride_q : ptr + stride_q;
  assign nxt_ptr = ptr + (stride_q << 1);
  assign odd_ptr = first_q + stride_q;

  always_comb begin
    unique case (st)
      ST_RD_L: rd_addr = left_a;
      ST_RD_R: rd_addr = right_a;
      default: rd_addr = ptr;
    endcase
  end

  assign cap_l     = (st == ST_RD_L);
  assign cap_r     = (st == ST_RD_R);
  assign solo      = (first_q == last_q);
  assign odd_phase = (ph == PH_ODD);
  assign we        = (st == ST_WR);
  assign wr_addr   = ptr;
  assign busy_o    = (st != ST_IDLE);
  assign ready_o   = (st == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      ph       <= PH_EVEN;
      ptr      <= '0;
      first_q  <= '0;
      last_q   <= '0;
      stride_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            first_q  <= PW'(first_i);
            last_q   <= PW'(last_i);
            stride_q <= PW'(stride_i);
            ptr      <= PW'(first_i);
            ph       <= PH_EVEN;
            st       <= ST_RD_L;
          end
        end
        ST_RD_L: st <= ST_RD_R;
        ST_RD_R: st <= ST_WR;
        ST_WR: begin
          if (nxt_ptr > last_q) begin
            if (ph == PH_EVEN && odd_ptr <= last_q) begin
              ph  <= PH_ODD;
              ptr <= odd_ptr;
              st  <= ST_RD_L;
            end else begin
              st <= ST_DONE;
            end
          end else begin
            ptr <= nxt_ptr;
            st  <= ST_RD_L;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R7: ready is a single-cycle pulse
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  // R7: ready only follows a write-back
  p_ready_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> $past(we));

  // R5: writes stay inside the run bounds
  p_write_span_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (wr_addr >= first_q && wr_addr <= last_q));

  // R3: the odd phase is entered only from a write-back
  p_odd_after_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(odd_phase) |-> $past(we));
endmodule

// File: rtl/lift53_datapath.sv
module lift53_datapath #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_l,
  input  logic              cap_r,
  input  logic              zero_nb,
  input  logic              odd_phase,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] result
);
  localparam int WW = DATA_W + 2;
  localparam logic signed [WW-1:0] ROUND = WW'(2);

  logic signed [DATA_W-1:0] nb_l, nb_r;
  logic signed [WW-1:0]     sum, corr, ctr, wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nb_l <= '0;
      nb_r <= '0;
    end else begin
      if (cap_l) nb_l <= zero_nb ? '0 : $signed(rd_data);
      if (cap_r) nb_r <= zero_nb ? '0 : $signed(rd_data);
    end
  end

  always_comb begin
    sum  = WW'(nb_l) + WW'(nb_r);
    ctr  = WW'($signed(rd_data));
    corr = odd_phase ? (sum >>> 1) : ((sum + ROUND) >>> 2);
    wide = odd_phase ? (ctr + corr) : (ctr - corr);
  end

  assign result = wide[DATA_W-1:0];
endmodule

// File: rtl/lift53_synth.sv
module lift53_synth #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] first_i,
  input  logic [ADDR_W-1:0] last_i,
  input  logic [ADDR_W-1:0] stride_i,
  output logic              busy_o,
  output logic              ready_o,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o
);
  localparam int PW = ADDR_W + 2;

  logic [PW-1:0]     rd_addr, wr_addr;
  logic [DATA_W-1:0] rd_data, wr_data;
  logic              cap_l, cap_r, solo, odd_phase, we;

  lift53_ctrl #(.ADDR_W(ADDR_W), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .first_i   (first_i),
    .last_i    (last_i),
    .stride_i  (stride_i),
    .busy_o    (busy_o),
    .ready_o   (ready_o),
    .rd_addr   (rd_addr),
    .cap_l     (cap_l),
    .cap_r     (cap_r),
    .solo      (solo),
    .odd_phase (odd_phase),
    .we        (we),
    .wr_addr   (wr_addr)
  );

  lift53_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_l     (cap_l),
    .cap_r     (cap_r),
    .zero_nb   (solo),
    .odd_phase (odd_phase),
    .rd_data   (rd_data),
    .result    (wr_data)
  );

  lift53_regfile #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .PW(PW)) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .eng_we     (we),
    .eng_waddr  (wr_addr),
    .eng_wdata  (wr_data),
    .eng_raddr  (rd_addr),
    .eng_rdata  (rd_data),
    .host_ok    (!busy_o),
    .host_we    (host_we_i),
    .host_addr  (host_addr_i),
    .host_wdata (host_wdata_i),
    .host_rdata (host_rdata_o)
  );

  // R6: a one-word run writes back exactly what it read
  p_solo_identity_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && solo) |-> (wr_data == rd_data));
endmodule

// File: tb/test_lift53_synth.sv
module test_lift53_synth;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] first_i = '0, last_i = '0, stride_i = '0;
  logic              busy_o, ready_o;
  logic              host_we_i = 1'b0;
  logic [ADDR_W-1:0] host_addr_i = '0;
  logic [DATA_W-1:0] host_wdata_i = '0;
  logic [DATA_W-1:0] host_rdata_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int mdl  [DEPTH];
  int sig  [DEPTH];
  int coef [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  lift53_synth #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_lift53_synth (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .first_i(first_i), .last_i(last_i),
    .stride_i(stride_i), .busy_o(busy_o), .ready_o(ready_o), .host_we_i(host_we_i),
    .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i), .host_rdata_o(host_rdata_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int mi(input int j, input int len);
    if (j < 0) return -j;
    if (j >= len) return 2 * (len - 1) - j;
    return j;
  endfunction

  // forward 5/3 lifting of sig[0..len-1] into coef
  task automatic fwd(input int len);
    for (int k = 0; k < len; k++) coef[k] = sig[k];
    if (len == 1) return;
    for (int k = 1; k < len; k += 2)
      coef[k] = sig[k] - ((sig[mi(k-1, len)] + sig[mi(k+1, len)]) >>> 1);
    for (int k = 0; k < len; k += 2)
      coef[k] = sig[k] + ((coef[mi(k-1, len)] + coef[mi(k+1, len)] + 2) >>> 2);
  endtask

  task automatic host_write(input int a, input int v);
    @(negedge clk);
    host_we_i = 1'b1;
    host_addr_i = ADDR_W'(a);
    host_wdata_i = DATA_W'(v);
    @(negedge clk);
    host_we_i = 1'b0;
    if (!busy_o) mdl[a] = v;
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      host_addr_i = ADDR_W'(a);
      #1;
      chk(int'($signed(host_rdata_o)) == mdl[a], req, int'($signed(host_rdata_o)), mdl[a]);
    end
  endtask

  // launch a run and check its timing and handshake (R7, R9)
  task automatic do_run(input int first, input int last, input int stride);
    int len = (last - first) / stride + 1;
    int n = 0;
    @(negedge clk);
    first_i = ADDR_W'(first);
    last_i = ADDR_W'(last);
    stride_i = ADDR_W'(stride);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy after start", int'(busy_o), 1);
    while (n < 1000) begin
      @(negedge clk);
      n++;
      if (ready_o) break;
    end
    chk(n == 3 * len, "R9 cycles to ready", n, 3 * len);
    chk(busy_o == 1'b1, "R7 busy in ready cycle", int'(busy_o), 1);
    @(negedge clk);
    chk(ready_o == 1'b0, "R7 ready one cycle", int'(ready_o), 0);
    chk(busy_o == 1'b0, "R7 busy drops", int'(busy_o), 0);
  endtask

  task automatic round_trip(input int first, input int stride, input int len, input int seed,
                            input string req);
    for (int k = 0; k < len; k++) sig[k] = ((k * 37 + seed * 13) % 151) - 75;
    fwd(len);
    for (int k = 0; k < len; k++) host_write(first + k * stride, coef[k]);
    do_run(first, first + (len - 1) * stride, stride);
    for (int k = 0; k < len; k++) mdl[first + k * stride] = sig[k];
    check_all(req);
  endtask

  task automatic t_reset;
    chk(ready_o == 1'b0, "R1 ready at reset", int'(ready_o), 0);
    chk(busy_o == 1'b0, "R1 busy at reset", int'(busy_o), 0);
    check_all("R1 words zero");
  endtask

  // hand coefficients, L=5 at stride 1 from address 4: R2 even, R3 odd
  task automatic t_direct;
    int y [5] = '{10, -7, 20, 3, -9};
    int x [5];
    for (int k = 0; k < 5; k++) host_write(4 + k, y[k]);
    // R2: even positions, mirrored d[-1]=d[1], d[5]=d[3]
    x[0] = 10 - ((-7 + -7 + 2) >>> 2);
    x[2] = 20 - ((-7 + 3 + 2) >>> 2);
    x[4] = -9 - ((3 + 3 + 2) >>> 2);
    // R3: odd positions from restored evens
    x[1] = -7 + ((x[0] + x[2]) >>> 1);
    x[3] = 3 + ((x[2] + x[4]) >>> 1);
    do_run(4, 8, 1);
    for (int k = 0; k < 5; k++) mdl[4 + k] = x[k];
    check_all("R2 R3 direct");
  endtask

  task automatic t_even_len;
    round_trip(0, 1, 8, 1, "R4 even length");
  endtask

  task automatic t_odd_len;
    round_trip(3, 2, 7, 2, "R4 odd length");
  endtask

  task automatic t_wide_stride;
    round_trip(1, 5, 6, 3, "R5 wide stride");
  endtask

  task automatic t_solo;
    host_write(9, -321);
    do_run(9, 9, 3);
    check_all("R6 single word");
  endtask

  task automatic t_busy_ignore;
    int pulses = 0;
    for (int k = 0; k < 4; k++) sig[k] = 5 * k - 6;
    fwd(4);
    for (int k = 0; k < 4; k++) host_write(20 + k, coef[k]);
    @(negedge clk);
    first_i = 5'd20; last_i = 5'd23; stride_i = 5'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    // R8: host write and a second start during the run
    host_we_i = 1'b1; host_addr_i = 5'd30; host_wdata_i = 16'd555;
    first_i = 5'd0; last_i = 5'd2; start_i = 1'b1;
    @(negedge clk);
    host_we_i = 1'b0; start_i = 1'b0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (ready_o) pulses++;
    end
    chk(pulses == 1, "R8 second start ignored", pulses, 1);
    for (int k = 0; k < 4; k++) mdl[20 + k] = sig[k];
    check_all("R8 busy host write ignored");
  endtask

  task automatic t_reject;
    int seen = 0;
    @(negedge clk);
    first_i = 5'd2; last_i = 5'd6; stride_i = 5'd0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R8 zero stride rejected", int'(busy_o), 0);
    first_i = 5'd7; last_i = 5'd3; stride_i = 5'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b0, "R8 reversed bounds rejected", int'(busy_o), 0);
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (ready_o || busy_o) seen++;
    end
    chk(seen == 0, "R8 no activity", seen, 0);
    check_all("R8 words untouched");
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) mdl[a] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_direct();
    t_even_len();
    t_odd_len();
    t_wide_stride();
    t_solo();
    t_busy_ignore();
    t_reject();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule